// File: doc/BRIEF.md
# Dual-Period Watchdog Timer

This block supervises a processor by watching a single strobe line for activity. Every change of level on the strobe, in either direction, proves the processor is alive and restarts a timeout count. When the count runs out without a change, the block asks the surrounding reset logic for a reset and drops a sticky status flag. The count advances on a timebase tick, so the same logic serves a fixed internal timebase or an external clock.

Two periods exist. After any reset the first period is always the long one, which gives the processor time to recover. Once the processor shows its first strobe change after the reset ends, the period selected by the mode input applies: short or long. A separate indication marks the strobe as floating, which disables the watchdog. While the supply is bad the watchdog is also off, the strobe is ignored and the status flag is held high.

The control is a four-state machine. HOLD keeps the timer cleared while reset is active. FIRST counts the long period after the end of reset. ARMED counts the selected period after the first strobe change. OFF is the disabled state while the strobe floats. The transitions are: any state to HOLD on supply loss (named SUPPLY_DROP); HOLD to FIRST on the end-of-reset pulse with good supply (RELEASE); FIRST to ARMED on a strobe change (ACTIVITY); ARMED to ARMED on a strobe change (RESTART); FIRST or ARMED to HOLD on expiry (EXPIRE); FIRST or ARMED to OFF when the strobe floats (DISABLE); OFF to FIRST once the strobe is driven again (ENABLE).

Top module: `wd_dual_period`

## Requirements
- R1: After `rst_ni` is released, `timeout_req_o` is 0 and `wd_status_o` is 1, and no request is made until `reset_done_i` has been seen high at a clock edge.
- R2: After the end-of-reset pulse, the first request arrives exactly LONG_TICKS ticks later when the strobe never changes, even with `short_sel_i` = 1.
- R3: After the first strobe change following end of reset, the period is SHORT_TICKS when `short_sel_i` = 1 and LONG_TICKS when `short_sel_i` = 0.
- R4: A rising or a falling strobe change restarts the count; a change applied to `strobe_i` takes effect at the third clock edge after it (two synchronizer flops plus the edge detector).
- R5: On expiry `timeout_req_o` is high for exactly one cycle and `wd_status_o` is 0 in that same cycle.
- R6: `wd_status_o` stays 0 after expiry until the next strobe change, which sets it to 1 (in any state while the supply is good).
- R7: While `strobe_float_i` is 1 the block makes no request and `wd_status_o` is 1; a level difference between before and after the floating interval is not a strobe change, and counting resumes with the long period.
- R8: While `supply_ok_i` is 0 no request is made, `wd_status_o` is 1, strobe changes are ignored and the timer is cleared; after the supply returns the timer stays cleared until the next end-of-reset pulse.
- R9: With no strobe activity, every end-of-reset pulse starts another long period, so requests repeat once per long period.
- R10: The count advances only at clock edges where `tick_i` is 1.
- R11: When a strobe change and an expiry fall in the same cycle, the change wins: no request is made and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Processor strobe level (asynchronous) |
| strobe_float_i | input | 1 | 1 when the strobe is left undriven (asynchronous) |
| supply_ok_i | input | 1 | 1 when the supply is above threshold (synchronous) |
| reset_done_i | input | 1 | One-cycle pulse marking the end of a reset |
| tick_i | input | 1 | Timebase tick enabling one count step |
| short_sel_i | input | 1 | 1 selects the short period once the processor is active |
| timeout_req_o | output | 1 | One-cycle reset request on expiry |
| wd_status_o | output | 1 | Sticky status, 0 after expiry |

## Verification
The two functions that can coincide are the restart by a strobe change and the expiry of the count. The bench provokes this by changing the strobe exactly three clock edges before the long period would run out, so that the synchronized change reaches the control in the cycle the counter reports expiry. It judges the outcome at the ports: no request may appear there, and the next request must come a full short period after the restart, which a design letting the expiry win would miss by a wide margin.

// File: rtl/wd_dual_period_pkg.sv
package wd_dual_period_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_FIRST = 2'd1,
        ST_ARMED = 2'd2,
        ST_OFF   = 2'd3
    } wd_state_t;

endpackage

// File: rtl/wd_strobe_front.sv
module wd_strobe_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_i,
    input  logic float_i,
    output logic edge_o,
    output logic float_o
);

    logic [SYNC_STAGES-1:0] lvl_q;
    logic [SYNC_STAGES-1:0] flt_q;
    logic                   lvl_prev_q;
    logic                   flt_prev_q;

    // Floating chain resets to 1 so no edge is seen until the level chain is primed.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lvl_q      <= '0;
            flt_q      <= '1;
            lvl_prev_q <= 1'b0;
            flt_prev_q <= 1'b1;
        end else begin
            lvl_q      <= {lvl_q[SYNC_STAGES-2:0], strobe_i};
            flt_q      <= {flt_q[SYNC_STAGES-2:0], float_i};
            lvl_prev_q <= lvl_q[SYNC_STAGES-1];
            flt_prev_q <= flt_q[SYNC_STAGES-1];
        end
    end

    assign float_o = flt_q[SYNC_STAGES-1];
    // A change is only valid when the line was driven in both samples compared.
    assign edge_o  = (lvl_q[SYNC_STAGES-1] != lvl_prev_q) && !float_o && !flt_prev_q;

endmodule

// File: rtl/wd_tick_counter.sv
module wd_tick_counter #(
    parameter int CW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          expire_o
);

    logic [CW-1:0] cnt_q;

    assign expire_o = tick_i && !clr_i && (cnt_q == limit_i - 1'b1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i || expire_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wd_ctrl_fsm.sv
module wd_ctrl_fsm
    import wd_dual_period_pkg::*;
#(
    parameter int CW          = 12,
    parameter int SHORT_TICKS = 1024,
    parameter int LONG_TICKS  = 4096
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          edge_i,
    input  logic          float_i,
    input  logic          supply_ok_i,
    input  logic          reset_done_i,
    input  logic          expire_i,
    input  logic          short_sel_i,
    output logic          clr_o,
    output logic [CW-1:0] limit_o,
    output logic          timeout_req_o,
    output logic          status_o
);

    localparam logic [CW-1:0] SHORT_L = CW'(SHORT_TICKS);
    localparam logic [CW-1:0] LONG_L  = CW'(LONG_TICKS);

    wd_state_t state_q;
    wd_state_t state_d;
    logic      counting;
    logic      timeout;

    assign counting = (state_q == ST_FIRST) || (state_q == ST_ARMED);
    // A strobe change in the expiry cycle takes priority over the expiry.
    assign timeout  = counting && expire_i && !edge_i && supply_ok_i && !float_i;
    assign clr_o    = !counting || edge_i;
    assign limit_o  = (state_q == ST_ARMED && short_sel_i) ? SHORT_L : LONG_L;

    always_comb begin
        state_d = state_q;
        if (!supply_ok_i) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    if (reset_done_i) state_d = ST_FIRST;
                end
                ST_FIRST, ST_ARMED: begin
                    if (float_i)      state_d = ST_OFF;
                    else if (edge_i)  state_d = ST_ARMED;
                    else if (timeout) state_d = ST_HOLD;
                end
                ST_OFF: begin
                    if (!float_i) state_d = ST_FIRST;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            timeout_req_o <= 1'b0;
            status_o      <= 1'b1;
        end else begin
            timeout_req_o <= timeout;
            if (!supply_ok_i || float_i || edge_i) begin
                status_o <= 1'b1;
            end else if (timeout) begin
                status_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wd_dual_period.sv
module wd_dual_period #(
    parameter int SHORT_TICKS = 1024,
    parameter int LONG_TICKS  = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_i,
    input  logic strobe_float_i,
    input  logic supply_ok_i,
    input  logic reset_done_i,
    input  logic tick_i,
    input  logic short_sel_i,
    output logic timeout_req_o,
    output logic wd_status_o
);

    localparam int CW = $clog2(LONG_TICKS + 1);

    logic          edge_s;
    logic          float_s;
    logic          clr_s;
    logic          expire_s;
    logic [CW-1:0] limit_s;

    wd_strobe_front #(
        .SYNC_STAGES(SYNC_STAGES)
    ) front_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .strobe_i(strobe_i),
        .float_i (strobe_float_i),
        .edge_o  (edge_s),
        .float_o (float_s)
    );

    wd_tick_counter #(
        .CW(CW)
    ) ctr_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr_s),
        .tick_i  (tick_i),
        .limit_i (limit_s),
        .expire_o(expire_s)
    );

    wd_ctrl_fsm #(
        .CW         (CW),
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS)
    ) fsm_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .edge_i       (edge_s),
        .float_i      (float_s),
        .supply_ok_i  (supply_ok_i),
        .reset_done_i (reset_done_i),
        .expire_i     (expire_s),
        .short_sel_i  (short_sel_i),
        .clr_o        (clr_s),
        .limit_o      (limit_s),
        .timeout_req_o(timeout_req_o),
        .status_o     (wd_status_o)
    );

endmodule

// File: rtl/wd_dual_period_chk.sv
module wd_dual_period_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic supply_ok_i,
    input logic float_s,
    input logic edge_s,
    input logic req,
    input logic status
);

    p_req_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req |=> !req);

    p_req_status_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req |-> !status);

    p_status_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_s && supply_ok_i) |=> status);

    p_float_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        float_s |=> (!req && status));

    p_supply_status_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_ok_i |=> status);

    p_supply_noreq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_ok_i |=> !req);

    p_edge_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_s |=> !req);

endmodule

bind wd_dual_period wd_dual_period_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .float_s    (float_s),
    .edge_s     (edge_s),
    .req        (timeout_req_o),
    .status     (wd_status_o)
);

// File: tb/wd_dual_period_tb_top.sv
`timescale 1ns/1ps
module wd_dual_period_tb_top;

    localparam int SHORT = 16;
    localparam int LONG  = 64;
    localparam int LAT   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0;
    logic flt = 1'b0;
    logic supply_ok = 1'b1;
    logic rst_done = 1'b0;
    logic tick = 1'b1;
    logic short_sel = 1'b1;
    logic tick_half = 1'b0;
    logic req;
    logic status;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    always @(negedge clk) tick <= tick_half ? ~tick : 1'b1;

    wd_dual_period #(
        .SHORT_TICKS(SHORT),
        .LONG_TICKS (LONG),
        .SYNC_STAGES(2)
    ) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .strobe_i      (strobe),
        .strobe_float_i(flt),
        .supply_ok_i   (supply_ok),
        .reset_done_i  (rst_done),
        .tick_i        (tick),
        .short_sel_i   (short_sel),
        .timeout_req_o (req),
        .wd_status_o   (status)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic do_reset(input bit sel);
        rst_n = 1'b0; strobe = 1'b0; flt = 1'b0; supply_ok = 1'b1;
        rst_done = 1'b0; short_sel = sel; tick_half = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk) rst_done = 1'b1;
        @(negedge clk) rst_done = 1'b0;
    endtask

    task automatic measure(input int max, output int n);
        n = -1;
        for (int i = 1; i <= max; i++) begin
            @(negedge clk);
            if (req) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic toggle();
        @(negedge clk) strobe = ~strobe;
    endtask

    task automatic t_reset();
        int n;
        do_reset(1'b1);
        check(req == 1'b0, "R1 req after reset", req, 0);
        check(status == 1'b1, "R1 status after reset", status, 1);
        measure(LONG + 10, n);
        check(n == -1, "R1 no request before end of reset", n, -1);
    endtask

    task automatic t_first_long();
        int n;
        do_reset(1'b1);
        pulse_done();
        measure(LONG + 20, n);
        check(n == LONG, "R2 first period long with short selected", n, LONG);
        check(status == 1'b0, "R5 status low with request", status, 0);
        @(negedge clk);
        check(req == 1'b0, "R5 request lasts one cycle", req, 0);
    endtask

    task automatic t_short();
        int n;
        do_reset(1'b1);
        pulse_done();
        repeat (5) @(negedge clk);
        toggle();
        repeat (8) @(negedge clk);
        check(req == 1'b0, "R4 no request after rising change", req, 0);
        toggle();
        measure(LONG + 20, n);
        check(n == LAT + SHORT, "R3 R4 short period after falling change", n, LAT + SHORT);
    endtask

    task automatic t_long_sel();
        int n;
        do_reset(1'b0);
        pulse_done();
        repeat (5) @(negedge clk);
        toggle();
        measure(LONG + 20, n);
        check(n == LAT + LONG, "R3 long period when short not selected", n, LAT + LONG);
    endtask

    task automatic t_sticky();
        int n;
        do_reset(1'b1);
        pulse_done();
        measure(LONG + 20, n);
        repeat (20) @(negedge clk);
        check(status == 1'b0, "R6 status stays low", status, 0);
        toggle();
        repeat (LAT + 1) @(negedge clk);
        check(status == 1'b1, "R6 change sets status", status, 1);
    endtask

    task automatic t_float();
        int n;
        do_reset(1'b1);
        pulse_done();
        measure(LONG + 20, n);
        pulse_done();
        flt = 1'b1;
        repeat (4) @(negedge clk);
        check(status == 1'b1, "R7 floating forces status high", status, 1);
        strobe = ~strobe;
        measure(LONG + 10, n);
        check(n == -1, "R7 no request while floating", n, -1);
        flt = 1'b0;
        measure(2 * LONG, n);
        check(n == LAT + LONG, "R7 driven again is no change, long period", n, LAT + LONG);
    endtask

    task automatic t_supply();
        int n;
        do_reset(1'b1);
        pulse_done();
        measure(LONG + 20, n);
        pulse_done();
        repeat (10) @(negedge clk);
        supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        check(status == 1'b1, "R8 status high on bad supply", status, 1);
        toggle();
        repeat (4) @(negedge clk);
        toggle();
        rst_done = 1'b1;
        @(negedge clk) rst_done = 1'b0;
        measure(LONG + 10, n);
        check(n == -1, "R8 no request while supply bad", n, -1);
        supply_ok = 1'b1;
        measure(LONG + 10, n);
        check(n == -1, "R8 timer held until end of reset", n, -1);
        pulse_done();
        measure(LONG + 20, n);
        check(n == LONG, "R8 long period after supply return", n, LONG);
    endtask

    task automatic t_repeat();
        int n;
        do_reset(1'b1);
        pulse_done();
        measure(LONG + 20, n);
        check(n == LONG, "R9 first repeat period", n, LONG);
        repeat (7) @(negedge clk);
        pulse_done();
        measure(LONG + 20, n);
        check(n == LONG, "R9 second repeat period", n, LONG);
    endtask

    task automatic t_tick();
        int n;
        do_reset(1'b1);
        tick_half = 1'b1;
        repeat (3) @(negedge clk);
        pulse_done();
        measure(3 * LONG, n);
        check(n == 2 * LONG - 1 || n == 2 * LONG, "R10 count only on ticks", n, 2 * LONG);
        tick_half = 1'b0;
    endtask

    task automatic t_collide();
        int n;
        do_reset(1'b1);
        pulse_done();
        repeat (LONG - LAT) @(negedge clk);
        strobe = ~strobe;
        measure(LONG + 20, n);
        check(n == LAT + SHORT, "R11 change wins over expiry", n, LAT + SHORT);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_first_long();
        t_short();
        t_long_sel();
        t_sticky();
        t_float();
        t_supply();
        t_repeat();
        t_tick();
        t_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule